// File: doc/BRIEF.md
# PCIe Slot Power-Up Reset Sequencer

This block brings a downstream PCIe slot out of power-off in a fixed order. After a start request it enables slot power and keeps the fundamental reset (PERST#, active low) asserted. Once the supply reports good, it enables the reference clock. It releases reset only after two conditions hold: power has been good for the hold interval, and the clock has been continuously stable for the clock interval. Both intervals are measured from the status inputs, not from the enables. A board margin is added to each interval.

After release, the block polls link-active within a bounded window. If the root port advertises a maximum speed above 5 GT/s, it then waits one further settle interval. Only after that does it grant configuration access. A poll that runs out parks the block in a failure state and sets a sticky timeout flag.

All intervals are given in milliseconds or microseconds. They are turned into cycle counts at elaboration from the clock frequency and a divisor, which can shrink them for simulation. The cycle count for an interval is:

    max(1, (us + margin_us) * (CLK_HZ / 1e6) / TIME_DIV)

Top module: `slot_reset_seq`

## Requirements
- R1: While rst_ni is low, and after reset, all outputs are low and state_o reads 0 (off). State codes are: 0 off, 1 power-on, 2 hold, 3 link poll, 4 post-train wait, 5 ready, 6 fail.
- R2: A start_i pulse in the off state raises pwr_en_o on the next edge (state 1). perst_no and refclk_en_o stay low until pwr_good_i is seen.
- R3: In state 1, a high pwr_good_i moves the block to state 2 on the next edge and raises refclk_en_o. refclk_en_o is never high without pwr_en_o.
- R4: With the clock already stable, perst_no is still low T_PWR+1 edges after pwr_good_i rises and is high one edge later. T_PWR counts the 100 ms hold plus the power margin.
- R5: perst_no is released only after clk_stable_i has been high for T_CLK consecutive edges in state 2. T_CLK counts the 100 us interval plus the clock margin. Any low cycle restarts that count.
- R6: In state 3, if link_active_i is not seen within T_LINK edges (100 ms), the block enters state 6. It then reasserts PERST#, keeps cfg_ok_o low and sets link_timeout_o. A later link_active_i is ignored.
- R7: If rp_max_speed_i is 1 or 2 (2.5 or 5 GT/s) when link-active is seen, cfg_ok_o rises on the next edge. If the code is 3 or higher (above 5 GT/s), the block waits in state 4, and cfg_ok_o rises T_POST+2 edges after link-active (100 ms settle).
- R8: When pwr_good_i is low in any state from 2 to 6, the next edge returns the block to off. That edge drops perst_no, pwr_en_o, refclk_en_o and cfg_ok_o.
- R9: link_timeout_o stays set until rst_ni, through power loss and through a later successful bring-up.
- R10: start_i has no effect outside the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin bring-up (off state only) |
| pwr_good_i | input | 1 | Slot supply within limits |
| clk_stable_i | input | 1 | Reference clock stable |
| link_active_i | input | 1 | Data link layer reports link up |
| rp_max_speed_i | input | SPD_W | Root port advertised maximum speed code |
| pwr_en_o | output | 1 | Slot power enable |
| refclk_en_o | output | 1 | Reference clock enable |
| perst_no | output | 1 | Fundamental reset to slot, active low |
| cfg_ok_o | output | 1 | Configuration access allowed |
| link_timeout_o | output | 1 | Sticky link-up timeout flag |
| state_o | output | 3 | Current sequencer state code |

## Verification
The hardest case to reach is a reset release held back by the clock interval rather than the power interval, since the power hold is normally the longer one. The stimulus keeps clk_stable_i low until the power hold has fully expired. It then raises it and pulses it low once partway through, so the release edge must fall exactly T_CLK+1 edges after the final rise. The timeout path is reached by withholding link-active for the whole poll window. A power cycle and a clean bring-up follow, to show the flag persists.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PWR_ON = 3'd1,
    ST_HOLD   = 3'd2,
    ST_POLL   = 3'd3,
    ST_POST   = 3'd4,
    ST_READY  = 3'd5,
    ST_FAIL   = 3'd6
  } seq_st_e;

  // interval in us -> cycles, never below one
  function automatic longint unsigned us_to_cyc(longint unsigned us, longint unsigned hz,
                                                longint unsigned div);
    longint unsigned c;
    c = (us * (hz / 64'd1_000_000)) / div;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i); // R4

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import slot_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    pwr_good_i,
  input  logic    clk_stable_i,
  input  logic    link_active_i,
  input  logic    fast_link_i,
  input  logic    a_done_i,
  input  logic    b_done_i,
  output logic    a_clr_o,
  output logic    a_run_o,
  output logic    b_clr_o,
  output logic    b_run_o,
  output seq_st_e state_o,
  output logic    pwr_en_o,
  output logic    refclk_en_o,
  output logic    perst_no,
  output logic    cfg_ok_o,
  output logic    timeout_o
);

  seq_st_e st_q, st_d;
  logic    tmo_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (start_i) st_d = ST_PWR_ON;
      ST_PWR_ON: if (pwr_good_i) st_d = ST_HOLD;
      ST_HOLD:   if (a_done_i && b_done_i) st_d = ST_POLL;
      ST_POLL: begin
        if (link_active_i) st_d = fast_link_i ? ST_POST : ST_READY;
        else if (a_done_i) st_d = ST_FAIL;
      end
      ST_POST:   if (a_done_i) st_d = ST_READY;
      ST_READY:  st_d = ST_READY;
      ST_FAIL:   st_d = ST_FAIL;
      default:   st_d = ST_OFF;
    endcase
    // supply loss overrides everything once power was seen
    if (st_q != ST_OFF && st_q != ST_PWR_ON && !pwr_good_i) st_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      tmo_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_POLL && st_d == ST_FAIL) tmo_q <= 1'b1;
    end
  end

  assign a_clr_o     = (st_d != st_q);
  assign a_run_o     = (st_q == ST_HOLD) || (st_q == ST_POLL) || (st_q == ST_POST);
  assign b_clr_o     = (st_q != ST_HOLD) || !clk_stable_i;
  assign b_run_o     = (st_q == ST_HOLD);

  assign state_o     = st_q;
  assign timeout_o   = tmo_q;
  assign pwr_en_o    = (st_q != ST_OFF);
  assign refclk_en_o = (st_q != ST_OFF) && (st_q != ST_PWR_ON);
  assign perst_no    = (st_q == ST_POLL) || (st_q == ST_POST) || (st_q == ST_READY);
  assign cfg_ok_o    = (st_q == ST_READY);

  AST_REFCLK_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refclk_en_o |-> pwr_en_o); // R3
  AST_RELEASE_AFTER_TIMERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perst_no) |-> $past(a_done_i && b_done_i)); // R4 R5
  AST_FAIL_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !cfg_ok_o || perst_no); // R6
  AST_SLOW_LINK_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_POLL && link_active_i && !fast_link_i && pwr_good_i) |=> cfg_ok_o); // R7
  AST_PWR_LOSS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_OFF && state_o != ST_PWR_ON && !pwr_good_i)
      |=> (!perst_no && !pwr_en_o && !cfg_ok_o)); // R8
  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o); // R9

endmodule

// File: rtl/slot_reset_seq.sv
module slot_reset_seq
  import slot_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ        = 250_000_000,
  parameter longint unsigned TIME_DIV      = 1,
  parameter longint unsigned HOLD_US       = 100_000,
  parameter longint unsigned CLK_US        = 100,
  parameter longint unsigned POLL_US       = 100_000,
  parameter longint unsigned POST_US       = 100_000,
  parameter longint unsigned PWR_MARGIN_US = 0,
  parameter longint unsigned CLK_MARGIN_US = 0,
  parameter int              SPD_W         = 4,
  parameter int              FAST_MIN      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pwr_good_i,
  input  logic             clk_stable_i,
  input  logic             link_active_i,
  input  logic [SPD_W-1:0] rp_max_speed_i,
  output logic             pwr_en_o,
  output logic             refclk_en_o,
  output logic             perst_no,
  output logic             cfg_ok_o,
  output logic             link_timeout_o,
  output logic [2:0]       state_o
);

  localparam longint unsigned T_PWR  = us_to_cyc(HOLD_US + PWR_MARGIN_US, CLK_HZ, TIME_DIV);
  localparam longint unsigned T_CLK  = us_to_cyc(CLK_US + CLK_MARGIN_US, CLK_HZ, TIME_DIV);
  localparam longint unsigned T_LINK = us_to_cyc(POLL_US, CLK_HZ, TIME_DIV);
  localparam longint unsigned T_POST = us_to_cyc(POST_US, CLK_HZ, TIME_DIV);
  localparam longint unsigned T_M1   = (T_PWR > T_LINK) ? T_PWR : T_LINK;
  localparam longint unsigned T_MAX  = (T_M1 > T_POST) ? T_M1 : T_POST;
  localparam int              A_W    = $clog2(T_MAX + 1);
  localparam int              B_W    = $clog2(T_CLK + 1);

  logic           a_clr, a_run, a_done, b_clr, b_run, b_done, fast_link;
  logic [A_W-1:0] a_lim;
  seq_st_e        st;

  assign fast_link = (rp_max_speed_i >= SPD_W'(FAST_MIN));

  always_comb begin
    unique case (st)
      ST_POLL: a_lim = A_W'(T_LINK);
      ST_POST: a_lim = A_W'(T_POST);
      default: a_lim = A_W'(T_PWR);
    endcase
  end

  seq_timer #(.W(A_W)) u_main_tmr (
    .clk_i, .rst_ni, .clr_i(a_clr), .run_i(a_run), .limit_i(a_lim), .done_o(a_done)
  );

  seq_timer #(.W(B_W)) u_clk_tmr (
    .clk_i, .rst_ni, .clr_i(b_clr), .run_i(b_run), .limit_i(B_W'(T_CLK)), .done_o(b_done)
  );

  seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .pwr_good_i, .clk_stable_i, .link_active_i,
    .fast_link_i(fast_link),
    .a_done_i(a_done), .b_done_i(b_done),
    .a_clr_o(a_clr), .a_run_o(a_run), .b_clr_o(b_clr), .b_run_o(b_run),
    .state_o(st),
    .pwr_en_o, .refclk_en_o, .perst_no, .cfg_ok_o,
    .timeout_o(link_timeout_o)
  );

  assign state_o = st;

endmodule

// File: tb/sim_slot_reset_seq.sv
module sim_slot_reset_seq;

  localparam longint unsigned HZ   = 250_000_000;
  localparam longint unsigned DIV  = 25_000;
  localparam longint unsigned PMAR = 2_000;
  localparam longint unsigned CMAR = 900;
  localparam int T_PWR  = int'(((100_000 + PMAR) * (HZ / 1_000_000)) / DIV); // 1020
  localparam int T_CLK  = int'(((100 + CMAR) * (HZ / 1_000_000)) / DIV);     // 10
  localparam int T_LINK = int'((100_000 * (HZ / 1_000_000)) / DIV);          // 1000
  localparam int T_POST = T_LINK;

  // {speed[3:0], link latency[7:0], expect post wait}
  localparam logic [12:0] VEC [6] = '{
    {4'd1, 8'd0,   1'b0},
    {4'd2, 8'd17,  1'b0},
    {4'd3, 8'd5,   1'b1},
    {4'd4, 8'd200, 1'b1},
    {4'd5, 8'd1,   1'b1},
    {4'd2, 8'd90,  1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, pg = 0, cs = 0, la = 0;
  logic [3:0] spd = 4'd1;
  logic pwr_en, refclk_en, perst_n, cfg_ok, tmo;
  logic [2:0] st;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  slot_reset_seq #(
    .CLK_HZ(HZ), .TIME_DIV(DIV), .PWR_MARGIN_US(PMAR), .CLK_MARGIN_US(CMAR)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwr_good_i(pg), .clk_stable_i(cs),
    .link_active_i(la), .rp_max_speed_i(spd), .pwr_en_o(pwr_en), .refclk_en_o(refclk_en),
    .perst_no(perst_n), .cfg_ok_o(cfg_ok), .link_timeout_o(tmo), .state_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // start, raise power good, wait until reset released (clock already stable)
  task automatic bring_up();
    @(negedge clk) start = 1;
    tick(1);
    chk("R2 state", st, 1); chk("R2 pwr_en", pwr_en, 1);
    chk("R2 refclk", refclk_en, 0); chk("R2 perst", perst_n, 0);
    @(negedge clk) start = 0; pg = 1;
    tick(1);
    chk("R3 state", st, 2); chk("R3 refclk", refclk_en, 1);
    tick(T_PWR);
    chk("R4 still held", perst_n, 0);
    tick(1);
    chk("R4 released", perst_n, 1);
  endtask

  task automatic power_off();
    @(negedge clk) pg = 0; la = 0;
    tick(1);
    chk("R8 state", st, 0); chk("R8 perst", perst_n, 0);
    chk("R8 pwr_en", pwr_en, 0); chk("R8 cfg", cfg_ok, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 state", st, 0); chk("R1 pwr_en", pwr_en, 0); chk("R1 refclk", refclk_en, 0);
    chk("R1 perst", perst_n, 0); chk("R1 cfg", cfg_ok, 0); chk("R1 tmo", tmo, 0);
    @(negedge clk) rst_n = 1; cs = 1;
    tick(2);
    chk("R1 idle after reset", st, 0);

    for (int i = 0; i < 6; i++) begin
      spd = VEC[i][12:9];
      bring_up();
      tick(int'(VEC[i][8:1]));
      @(negedge clk) la = 1;
      tick(1);
      if (VEC[i][0]) begin
        chk("R7 post state", st, 4); chk("R7 post cfg", cfg_ok, 0);
        tick(T_POST);
        chk("R7 post still waiting", cfg_ok, 0);
        tick(1);
        chk("R7 post done", cfg_ok, 1);
      end else begin
        chk("R7 slow cfg", cfg_ok, 1); chk("R7 slow state", st, 5);
      end
      if (i == 1) begin
        @(negedge clk) start = 1;
        tick(1);
        @(negedge clk) start = 0;
        chk("R10 start ignored", st, 5);
      end
      power_off();
    end

    // clock interval dominates, with a restart
    @(negedge clk) cs = 0; start = 1;
    tick(1);
    @(negedge clk) start = 0; pg = 1;
    tick(T_PWR + 3);
    chk("R5 held without clock", perst_n, 0); chk("R5 state", st, 2);
    @(negedge clk) cs = 1;
    tick(T_CLK - 3);
    @(negedge clk) cs = 0;
    tick(1);
    @(negedge clk) cs = 1;
    tick(T_CLK);
    chk("R5 held after restart", perst_n, 0);
    tick(1);
    chk("R5 released", perst_n, 1);
    power_off();

    // link-up timeout
    spd = 4'd2;
    bring_up();
    tick(T_LINK);
    chk("R6 polling", st, 3);
    tick(1);
    chk("R6 fail state", st, 6); chk("R6 tmo", tmo, 1);
    chk("R6 perst", perst_n, 0); chk("R6 cfg", cfg_ok, 0);
    @(negedge clk) la = 1;
    tick(2);
    chk("R6 late link ignored", st, 6); chk("R6 late link cfg", cfg_ok, 0);
    power_off();
    chk("R9 tmo after power loss", tmo, 1);
    bring_up();
    @(negedge clk) la = 1;
    tick(1);
    chk("R9 retry ready", cfg_ok, 1); chk("R9 tmo after success", tmo, 1);
    @(negedge clk) rst_n = 0;
    tick(1);
    chk("R9 tmo cleared by reset", tmo, 0); chk("R1 reset mid-run", st, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule